// File: doc/BRIEF.md
# Wake Event Latch Unit

The unit watches a group of up to 32 wake sources, such as package pins or interrupt lines from peripherals, and records chosen transitions on them in sticky status bits. Each source has a polarity bit that selects a rising or a falling transition. Each source also has an enable bit that decides whether its recorded event may raise the single wake request output. A transition is recorded whether or not its source is enabled. A recorded event stays pending until software writes a one to its status bit, or until the interrupt controller acknowledges the matching interrupt through a dedicated clear vector.

Sources are asynchronous. They pass through a synchroniser chain and then an edge detector. The detector is held off until the chain carries real data after reset, so a line that already sits at its idle level does not fake an edge. Software reaches four registers over a simple register bus. The enable and polarity registers are read/write. The masked status register is read-only. The raw status register reads the recorded events and clears bits when a one is written.

Top module: `wake_latch_unit`

## Requirements
- R1: After reset, the enable register reads 0, the polarity register reads the `POL_INIT` parameter, raw and masked status read 0, and `wake_req` is low. Register selects are 0 enable, 1 polarity, 2 masked status, 3 raw status.
- R2: When a source's polarity bit is 1, a 0-to-1 transition on that source sets its raw status bit. When the bit is 0, a 1-to-0 transition sets it. A transition in the other direction has no effect.
- R3: Writing select 3 clears each raw status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A raw status bit is set by its edge even when the source is disabled.
- R5: Masked status (select 2) reads as raw status AND enable.
- R6: `wake_req` is high exactly when some masked status bit is set, and it stays high until the bit is cleared or disabled.
- R7: A source change driven before a clock edge shows in raw status after the third rising clock edge and not after the second (two synchroniser stages plus the latch).
- R8: A source that is already at its active level while reset is applied does not record an event once reset is released.
- R9: A 1 on bit i of `ack_clr` clears raw status bit i in the next cycle.
- R10: If an edge is detected in the same cycle as a clear of that bit, the bit ends up set.
- R11: Writes to select 2 change no register.
- R12: Changing a polarity bit while the source is steady records no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| src_in | input | NUM_SRC | Asynchronous wake sources |
| ack_clr | input | NUM_SRC | Per-source clear from interrupt acknowledge |
| wake_req | output | 1 | Wake request |

## Verification
The sources are driven with rising pulses, falling pulses and wrong-direction transitions, which separates the two polarity settings and shows that only the selected edge latches. Transitions are applied to disabled sources and then the source is enabled, so recording and masking can be told apart. A clear is made to coincide with a fresh edge, and a line is held at its active level through reset. These cases show set-over-clear priority and the start-up hold-off. Polarity flips on a steady line and writes to the read-only select confirm that neither disturbs state.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        SEL_ENABLE   = 2'd0,
        SEL_POLARITY = 2'd1,
        SEL_PENDING  = 2'd2,
        SEL_LATCHED  = 2'd3
    } wake_sel_e;

    typedef struct packed {
        logic             wr;
        wake_sel_e        sel;
        logic [BUS_W-1:0] data;
    } wake_bus_t;

    // Per-bit selected transition: rising when pol=1, falling when pol=0.
    function automatic logic pick_edge(logic pol, logic now_v, logic old_v);
        return pol ? (now_v & ~old_v) : (~now_v & old_v);
    endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/wake_edge.sv
module wake_edge #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sync_in,
    input  logic [N-1:0] pol,
    output logic [N-1:0] edge_hit
);
    import wake_pkg::*;

    localparam int ARM_LAST = STAGES + 1;
    localparam int CNT_W    = $clog2(ARM_LAST + 1);

    logic [N-1:0]     prev_q;
    logic [CNT_W-1:0] arm_cnt;
    logic             armed;

    assign armed = (arm_cnt == CNT_W'(ARM_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            arm_cnt <= '0;
        end else begin
            prev_q <= sync_in;
            if (!armed) arm_cnt <= arm_cnt + 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign edge_hit[i] = armed & pick_edge(pol[i], sync_in[i], prev_q[i]);
        end
    endgenerate
endmodule

// File: rtl/wake_regs.sv
module wake_regs #(
    parameter int          N        = 32,
    parameter logic [31:0] POL_INIT = 32'h0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wake_pkg::wake_bus_t        bus,
    input  logic [N-1:0]               edge_hit,
    input  logic [N-1:0]               ack_clr,
    output logic [N-1:0]               en_q,
    output logic [N-1:0]               pol_q,
    output logic [N-1:0]               raw_q,
    output logic [wake_pkg::BUS_W-1:0] rdata
);
    import wake_pkg::*;

    logic [N-1:0] sw_clr;
    logic [N-1:0] raw_n;
    logic [N-1:0] pend;

    assign sw_clr = (bus.wr && bus.sel == SEL_LATCHED) ? bus.data[N-1:0] : '0;
    // A new edge wins over any clear in the same cycle.
    assign raw_n  = (raw_q & ~(sw_clr | ack_clr)) | edge_hit;
    assign pend   = raw_q & en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pol_q <= POL_INIT[N-1:0];
            raw_q <= '0;
        end else begin
            raw_q <= raw_n;
            if (bus.wr && bus.sel == SEL_ENABLE)   en_q  <= bus.data[N-1:0];
            if (bus.wr && bus.sel == SEL_POLARITY) pol_q <= bus.data[N-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (bus.sel)
            SEL_ENABLE:   rdata[N-1:0] = en_q;
            SEL_POLARITY: rdata[N-1:0] = pol_q;
            SEL_PENDING:  rdata[N-1:0] = pend;
            SEL_LATCHED:  rdata[N-1:0] = raw_q;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/wake_latch_unit.sv
module wake_latch_unit #(
    parameter int          NUM_SRC     = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] POL_INIT    = 32'h0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] ack_clr,
    output logic               wake_req
);
    import wake_pkg::*;

    wake_bus_t          bus;
    logic [NUM_SRC-1:0] sync_v;
    logic [NUM_SRC-1:0] edge_hit;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pol_q;
    logic [NUM_SRC-1:0] raw_q;

    assign bus.wr   = reg_wr;
    assign bus.sel  = wake_sel_e'(reg_addr);
    assign bus.data = reg_wdata;

    wake_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(src_in), .sync_out(sync_v)
    );

    wake_edge #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .sync_in(sync_v), .pol(pol_q), .edge_hit(edge_hit)
    );

    wake_regs #(.N(NUM_SRC), .POL_INIT(POL_INIT)) u_regs (
        .clk(clk), .rst(rst), .bus(bus), .edge_hit(edge_hit), .ack_clr(ack_clr),
        .en_q(en_q), .pol_q(pol_q), .raw_q(raw_q), .rdata(reg_rdata)
    );

    assign wake_req = |(raw_q & en_q);
endmodule

// File: rtl/wake_latch_unit_chk.sv
module wake_latch_unit_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_wr,
    input logic [1:0]   reg_addr,
    input logic [31:0]  reg_wdata,
    input logic [N-1:0] ack_clr,
    input logic [N-1:0] edge_hit,
    input logic [N-1:0] raw_q,
    input logic [N-1:0] en_q,
    input logic         wake_req
);
    logic [N-1:0] clr_any;
    assign clr_any = ack_clr | ((reg_wr && reg_addr == 2'd3) ? reg_wdata[N-1:0] : '0);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_q == '0 && !wake_req));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd3) |=> ((raw_q & $past(reg_wdata[N-1:0] & ~edge_hit)) == '0));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~raw_q & $past(raw_q & ~clr_any)) == '0));

    assert_no_wake_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !wake_req);

    assert_set_needs_edge_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(edge_hit)) == '0));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_clr != '0) |=> ((raw_q & $past(ack_clr & ~edge_hit)) == '0));
endmodule

bind wake_latch_unit wake_latch_unit_chk #(.N(NUM_SRC)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ack_clr(ack_clr), .edge_hit(edge_hit),
    .raw_q(raw_q), .en_q(en_q), .wake_req(wake_req)
);

// File: tb/wake_latch_unit_bench.sv
`timescale 1ns/1ps
module wake_latch_unit_bench;
    localparam int          N    = 32;
    localparam logic [31:0] PINI = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] src_in = '0;
    logic [N-1:0] ack_clr = '0;
    logic        wake_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] pol_sw = PINI;

    always #2.5 clk = ~clk;

    wake_latch_unit #(.NUM_SRC(N), .SYNC_STAGES(2), .POL_INIT(PINI)) u_wake_latch_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
        .ack_clr(ack_clr), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        reg_read(a, d);
        check(req, d, exp);
    endtask

    // R1, R8: reset state; bit 0 (rising by default) held high through reset.
    task automatic t_reset();
        src_in[0] = 1'b1;
        cycles(3);
        rst = 1'b0;
        cycles(1);
        expect_reg("R1 enable", 2'd0, 32'h0);
        expect_reg("R1 polarity", 2'd1, PINI);
        expect_reg("R1 pending", 2'd2, 32'h0);
        expect_reg("R1 raw", 2'd3, 32'h0);
        check("R1 wake", {31'b0, wake_req}, 32'h0);
        cycles(6);
        expect_reg("R8 no start-up event", 2'd3, 32'h0);
    endtask

    // R2, R4, R7: rising edge on disabled source 3, latency.
    task automatic t_rise_disabled();
        pol_sw = pol_sw | 32'h8;
        reg_write(2'd1, pol_sw);
        cycles(1);
        src_in[3] = 1'b1;
        cycles(2);
        expect_reg("R7 not after two edges", 2'd3, 32'h0);
        cycles(1);
        expect_reg("R7/R4 raw after three edges", 2'd3, 32'h8);
        expect_reg("R5 pending disabled", 2'd2, 32'h0);
        check("R4 wake while disabled", {31'b0, wake_req}, 32'h0);
    endtask

    // R5, R6: enable reveals pending event.
    task automatic t_enable();
        reg_write(2'd0, 32'h8);
        expect_reg("R5 pending", 2'd2, 32'h8);
        check("R6 wake high", {31'b0, wake_req}, 32'h1);
        cycles(5);
        check("R6 wake stays", {31'b0, wake_req}, 32'h1);
    endtask

    // R3: write-one-to-clear.
    task automatic t_w1c();
        reg_write(2'd3, 32'h20);
        expect_reg("R3 zero bits untouched", 2'd3, 32'h8);
        reg_write(2'd3, 32'h8);
        expect_reg("R3 cleared", 2'd3, 32'h0);
        check("R6 wake low after clear", {31'b0, wake_req}, 32'h0);
    endtask

    // R2: falling polarity on bit 7.
    task automatic t_fall();
        src_in[7] = 1'b1;
        cycles(5);
        expect_reg("R2 wrong direction ignored", 2'd3, 32'h0);
        src_in[7] = 1'b0;
        cycles(3);
        expect_reg("R2 falling latched", 2'd3, 32'h80);
    endtask

    // R9: acknowledge clear.
    task automatic t_ack();
        ack_clr[7] = 1'b1;
        cycles(1);
        ack_clr = '0;
        expect_reg("R9 ack clears", 2'd3, 32'h0);
    endtask

    // R10: clear coincides with new edge on bit 3.
    task automatic t_set_wins();
        src_in[3] = 1'b0;
        cycles(4);
        expect_reg("R2 falling ignored on rising bit", 2'd3, 32'h0);
        src_in[3] = 1'b1;
        cycles(2);
        reg_write(2'd3, 32'h8);
        expect_reg("R10 set wins", 2'd3, 32'h8);
        reg_write(2'd3, 32'h8);
        expect_reg("R3 later clear", 2'd3, 32'h0);
    endtask

    // R11: writes to masked status are ignored.
    task automatic t_ro_write();
        src_in[3] = 1'b0; cycles(4);
        src_in[3] = 1'b1; cycles(4);
        reg_write(2'd2, 32'hFFFF_FFFF);
        expect_reg("R11 enable kept", 2'd0, 32'h8);
        expect_reg("R11 polarity kept", 2'd1, pol_sw);
        expect_reg("R11 raw kept", 2'd3, 32'h8);
        reg_write(2'd3, 32'h8);
    endtask

    // R12: polarity flip on a steady line.
    task automatic t_pol_flip();
        src_in[10] = 1'b1;
        cycles(5);
        reg_write(2'd1, pol_sw | 32'h400);
        cycles(5);
        reg_write(2'd1, pol_sw);
        cycles(5);
        expect_reg("R12 no event on polarity change", 2'd3, 32'h0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_rise_disabled();
                t_enable();
                t_w1c();
                t_fall();
                t_ack();
                t_set_wins();
                t_ro_write();
                t_pol_flip();
            end
            begin
                cycles(20000);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule